// File: doc/BRIEF.md
# Carry and Half-Carry Arithmetic/Rotate Unit

This block is the flag-producing datapath of a small 8-bit processor core. It takes an accumulator operand, a second operand and a 3-bit operation code. It performs add with carry, subtract with carry, a rotate right through carry, a rotate left through carry, set-carry or clear-carry. Both the 8-bit result and the status word are registered and appear after the clock edge on which `op_valid` is high.

The status word is eight bits wide. Bit 7 is the half-carry flag and bit 6 is the carry flag. Bits 5 to 0 hold interrupt enable and pending bits that belong to other logic. The unit stores those six bits and returns them on `status`, but it never changes or interprets them. Every operation that touches the carry also touches the half-carry. A direct write through `sw_wr` loads all eight status bits at once.

Top module: `carry_alu`

## Requirements
- R1: While `rst_n` is low and after it is released, `result` and `status` are 0 until the first operation or write.
- R2: Opcode 3'b001 (add with carry) returns (A + B + C) mod 256. C becomes the carry out of bit 7, and HC (status bit 7) becomes the carry out of bit 3, which is ((A mod 16) + (B mod 16) + C) >= 16. C is status bit 6.
- R3: Opcode 3'b010 (subtract with carry) returns A - B - (1 - C) mod 256. C becomes 1 exactly when no borrow occurs (A >= B + 1 - C). HC becomes 1 exactly when the low nibble does not borrow.
- R4: Opcode 3'b011 (rotate right through carry) returns {C, A[7:1]}. C and HC both become A[0].
- R5: Opcode 3'b100 (rotate left through carry) returns {A[6:0], C}. C and HC both become A[7].
- R6: Opcode 3'b101 (set carry) sets both C and HC to 1, and `result` takes A.
- R7: Opcode 3'b110 (clear carry) clears both C and HC to 0, and `result` takes A.
- R8: Opcodes 3'b000 and 3'b111 leave C and HC unchanged, and `result` takes A.
- R9: No operation changes status bits 5 to 0. They read back on `status` exactly as last written.
- R10: When `sw_wr` is high, `status` takes `sw_wdata` on that edge. This happens even if an operation is issued in the same cycle. That operation still updates `result`.
- R11: `result` and `status` change only on an edge where `op_valid` or `sw_wr` is high, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute `op_code` on this edge |
| op_code | input | 3 | Operation select |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B |
| sw_wr | input | 1 | Direct status write strobe |
| sw_wdata | input | 8 | Status value for a direct write |
| result | output | 8 | Registered operation result |
| status | output | 8 | Status word: HC, C, six stored bits |

## Verification
The bench sweeps every accumulator value against a spread of second operands, with both carry-in values, for add and subtract. It aims at the nibble boundary, where a design that takes half-carry from the wrong bit, or inverts the borrow sense, reports a wrong HC flag while the result is still correct. Every byte is also rotated in both directions with both carry-in values. This catches a rotate that drops the old carry or leaves HC stale. The bench also drives a status write together with an operation in the same cycle, and checks that the six stored bits survive every operation. A design with the wrong priority, or that masks those bits, returns a corrupted status word.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;
  typedef enum logic [2:0] {
    OP_NOP0 = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBC = 3'd2,
    OP_RORC = 3'd3,
    OP_ROLC = 3'd4,
    OP_SETC = 3'd5,
    OP_CLRC = 3'd6,
    OP_NOP7 = 3'd7
  } alu_op_e;

  localparam int SW_W   = 8;
  localparam int HC_BIT = 7;
  localparam int C_BIT  = 6;
  localparam int AUX_W  = 6;
endpackage

// File: rtl/carry_alu_arith.sv
module carry_alu_arith
  import carry_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic            c_new,
  output logic            h_new,
  output logic            flag_touch
);
  localparam int NIB = DW / 2;

  // Returns {half_carry, carry, sum}
  function automatic logic [DW+1:0] add3(input logic [DW-1:0] x,
                                         input logic [DW-1:0] y,
                                         input logic c);
    logic [NIB:0] lo;
    logic [DW:0]  full;
    lo   = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, c};
    full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
    return {lo[NIB], full};
  endfunction

  logic [DW+1:0] add_o;
  logic [DW+1:0] sub_o;

  assign add_o = add3(a, b, cin);
  assign sub_o = add3(a, ~b, cin);

  always_comb begin
    res        = a;
    c_new      = cin;
    h_new      = 1'b0;
    flag_touch = 1'b1;
    unique case (op)
      OP_ADDC: begin res = add_o[DW-1:0]; c_new = add_o[DW]; h_new = add_o[DW+1]; end
      OP_SUBC: begin res = sub_o[DW-1:0]; c_new = sub_o[DW]; h_new = sub_o[DW+1]; end
      OP_RORC: begin res = {cin, a[DW-1:1]}; c_new = a[0];    h_new = a[0];    end
      OP_ROLC: begin res = {a[DW-2:0], cin}; c_new = a[DW-1]; h_new = a[DW-1]; end
      OP_SETC: begin c_new = 1'b1; h_new = 1'b1; end
      OP_CLRC: begin c_new = 1'b0; h_new = 1'b0; end
      default: flag_touch = 1'b0;
    endcase
  end
endmodule

// File: rtl/carry_alu_status.sv
module carry_alu_status
  import carry_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SW_W-1:0] wdata,
  input  logic            flag_upd,
  input  logic            c_new,
  input  logic            h_new,
  output logic [SW_W-1:0] sw_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_q <= '0;
    else if (wr)
      sw_q <= wdata;
    else if (flag_upd) begin
      sw_q[HC_BIT] <= h_new;
      sw_q[C_BIT]  <= c_new;
    end
  end

  // R10: direct write loads all bits
  a_r10_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> sw_q == $past(wdata));
  // R9: stored bits untouched without a write
  a_r9_aux_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(sw_q[AUX_W-1:0]));
  // R8: flags hold when no flag update
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !flag_upd) |=> $stable(sw_q[HC_BIT:C_BIT]));
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   opnd_in,
  input  logic            sw_wr,
  input  logic [SW_W-1:0] sw_wdata,
  output logic [DW-1:0]   result,
  output logic [SW_W-1:0] status
);
  logic [DW-1:0] alu_res;
  logic          alu_c;
  logic          alu_h;
  logic          alu_touch;
  logic          flag_upd;

  carry_alu_arith #(.DW(DW)) u_arith (
    .op         (alu_op_e'(op_code)),
    .a          (acc_in),
    .b          (opnd_in),
    .cin        (status[C_BIT]),
    .res        (alu_res),
    .c_new      (alu_c),
    .h_new      (alu_h),
    .flag_touch (alu_touch)
  );

  assign flag_upd = op_valid && alu_touch;

  carry_alu_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (sw_wr),
    .wdata    (sw_wdata),
    .flag_upd (flag_upd),
    .c_new    (alu_c),
    .h_new    (alu_h),
    .sw_q     (status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      result <= '0;
    else if (op_valid)
      result <= alu_res;
  end

  // R6: set carry forces both flags high
  a_r6_setc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && op_code == 3'd5) |=> status[HC_BIT:C_BIT] == 2'b11);
  // R7: clear carry forces both flags low
  a_r7_clrc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && op_code == 3'd6) |=> status[HC_BIT:C_BIT] == 2'b00);
  // R4: rotate right takes old carry into the top bit
  a_r4_rorc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd3) |=> result == {$past(status[C_BIT]), $past(acc_in[DW-1:1])});
  // R5: rotate left takes old carry into the bottom bit
  a_r5_rolc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> result == {$past(acc_in[DW-2:0]), $past(status[C_BIT])});
  // R4/R5: rotates load HC equal to the new carry
  a_r4_rot_hc_eq_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !sw_wr && (op_code == 3'd3 || op_code == 3'd4))
      |=> status[HC_BIT] == status[C_BIT]);
  // R11: result holds without an operation
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result));
endmodule

// File: tb/carry_alu_bench.sv
module carry_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd_in = 8'd0;
  logic       sw_wr = 1'b0;
  logic [7:0] sw_wdata = 8'd0;
  logic [7:0] result;
  logic [7:0] status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  carry_alu u_carry_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .result(result), .status(status)
  );

  task automatic check(input string req, input logic [7:0] gr, input logic [7:0] er,
                       input logic [7:0] gs, input logic [7:0] es);
    n_cmp++;
    if (gr !== er || gs !== es) begin
      n_bad++;
      $display("FAIL %s: result=%02h status=%02h expected result=%02h status=%02h",
               req, gr, gs, er, es);
    end
  endtask

  task automatic wr_status(input logic [7:0] v);
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = v;
    @(posedge clk);
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = b;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // expected model for one operation given the starting status
  task automatic model(input logic [2:0] op, input int a, input int b, input logic [7:0] st,
                       output logic [7:0] er, output logic [7:0] es);
    int c, bw, r;
    logic hc, cy;
    c = int'(st[6]);
    er = a[7:0]; hc = st[7]; cy = st[6];
    case (op)
      3'd1: begin
        r = a + b + c; er = r[7:0]; cy = (r > 255); hc = ((a % 16) + (b % 16) + c) >= 16;
      end
      3'd2: begin
        bw = 1 - c; r = a - b - bw; er = r[7:0];
        cy = (a >= b + bw); hc = ((a % 16) >= (b % 16) + bw);
      end
      3'd3: begin er = {st[6], a[7:1]}; cy = a[0]; hc = a[0]; end
      3'd4: begin er = {a[6:0], st[6]}; cy = a[7]; hc = a[7]; end
      3'd5: begin cy = 1'b1; hc = 1'b1; end
      3'd6: begin cy = 1'b0; hc = 1'b0; end
      default: ;
    endcase
    es = {hc, cy, st[5:0]};
  endtask

  task automatic op_check(input string req, input logic [2:0] op, input int a, input int b,
                          input logic [7:0] st0);
    logic [7:0] er, es;
    wr_status(st0);
    model(op, a, b, st0, er, es);
    run_op(op, a[7:0], b[7:0]);
    check(req, result, er, status, es);
  endtask

  initial begin
    logic [7:0] held_r, held_s;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", result, 8'h00, status, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", result, 8'h00, status, 8'h00);

    // R2/R3 near-exhaustive sweeps, R9 stored bits ride along
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 11) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [7:0] st0;
          st0 = {(ci == 0), ci[0], 6'(a ^ b)};
          op_check("R2 add with carry / R9", 3'd1, a, b, st0);
          op_check("R3 subtract with carry / R9", 3'd2, a, b, st0);
        end
      end
      for (int ci = 0; ci < 2; ci++) begin
        logic [7:0] st1;
        st1 = {1'b0, ci[0], 6'(a)};
        op_check("R4 rotate right", 3'd3, a, 0, st1);
        st1 = {ci[0], ci[0], 6'(~a)};
        op_check("R5 rotate left", 3'd4, a, 0, st1);
      end
    end
    // nibble and byte boundary corners
    op_check("R2 nibble edge", 3'd1, 8'h0F, 8'h00, 8'h40);
    op_check("R2 full wrap", 3'd1, 8'hFF, 8'h00, 8'h40);
    op_check("R3 zero minus one", 3'd2, 8'h00, 8'h00, 8'h00);
    op_check("R3 equal no borrow", 3'd2, 8'h10, 8'h10, 8'h40);

    // R6/R7/R8 from several starting states
    for (int s = 0; s < 4; s++) begin
      logic [7:0] st2;
      st2 = {s[1:0], 6'h2A ^ 6'(s)};
      op_check("R6 set carry", 3'd5, 8'h5A + s, 8'h33, st2);
      op_check("R7 clear carry", 3'd6, 8'hA5 + s, 8'h33, st2);
      op_check("R8 no-op 0", 3'd0, 8'h3C + s, 8'h99, st2);
      op_check("R8 no-op 7", 3'd7, 8'hC3 + s, 8'h99, st2);
    end

    // R10 write and operation in the same cycle
    wr_status(8'hC0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd6; acc_in = 8'h77; opnd_in = 8'h00;
    sw_wr = 1'b1; sw_wdata = 8'hD5;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; sw_wr = 1'b0;
    check("R10 write beats clear carry", result, 8'h77, status, 8'hD5);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd1; acc_in = 8'hFF; opnd_in = 8'h01;
    sw_wr = 1'b1; sw_wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; sw_wr = 1'b0;
    check("R10 write beats add, result still updated", result, 8'h01, status, 8'h00);

    // R11 idle cycles hold everything, operands wiggling
    held_r = result; held_s = status;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op_code = 3'(k); acc_in = 8'(k * 37); opnd_in = 8'(k * 91);
      @(posedge clk); @(negedge clk);
      check("R11 hold without strobe", result, held_r, status, held_s);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule